// File: doc/BRIEF.md
# Delayed Register-Update Queue

This block holds a small bank of 64-bit target registers and a circular queue of writes to them that are scheduled to land later. Each queued write names a target register, a delay measured in ticks, a width (32 or 64 bits), a 64-bit value and, optionally, a single bit position. Every pulse on the tick input counts down all pending writes at once. A write takes effect on the tick at which its delay runs out. It either replaces the register, with a 32-bit write zero-filling the upper half, or sets or clears one bit.

Writes can take effect in any order, because a later write with a shorter delay lands first. Queue slots are still released strictly from the head. An entry that has already been applied while further back in the queue is marked as done. When it later reaches the head, it is released without being applied a second time. The register contents are always visible on a flat read bus. A consistency flag reports a pointer mismatch on an empty queue.

Top module: `regupd_queue`

## Requirements
- R1: After reset, every target register reads zero, the queue is empty, `full` is low and `err` is low.
- R2: Each tick lowers the remaining delay of every pending, not-yet-applied entry by one. The update becomes visible on `regs_o` in the cycle after the tick that brings the delay to zero. An enqueued delay of 0 behaves as 1. An entry accepted in a tick cycle is not counted down by that tick. Without a tick, `regs_o` does not change.
- R3: A full-width value write (`enq_bit_en`=0, `enq_wide`=1) replaces all 64 bits of the target register.
- R4: A narrow value write (`enq_bit_en`=0, `enq_wide`=0) loads `enq_value[31:0]` into bits 31:0 and zeroes bits 63:32.
- R5: A wide bit update (`enq_bit_en`=1, `enq_wide`=1) acts on bit `enq_bit[5:0]`. It sets that bit when any bit of `enq_value` is 1 and clears it otherwise. All other bits are unchanged.
- R6: A narrow bit update (`enq_bit_en`=1, `enq_wide`=0) acts on bit `enq_bit[4:0]` in the low 32 bits, with the same set or clear rule. Bits 63:32 and the other low bits are unchanged.
- R7: Entries are applied as soon as their own delay expires, regardless of queue position. When several entries expire on the same tick, they are applied in queue order from the head, so the entry nearest the tail wins on a shared register.
- R8: On a tick, the queue releases the longest run of entries, starting at the head, that are applied or become applied on that tick. An entry applied away from the head is never applied again.
- R9: The queue holds `SLOTS` entries (default 8). `full` is high exactly when all slots are occupied. An enqueue while `full` is high is dropped and never reaches any register.
- R10: `err` is high when the write and release pointers differ while the occupancy count is zero. It stays low in normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue a write this cycle |
| enq_tgt | input | TGT_W | Target register index |
| enq_delay | input | DLY_W | Ticks until the write takes effect (0 treated as 1) |
| enq_wide | input | 1 | 1: 64-bit target view, 0: 32-bit target view |
| enq_bit_en | input | 1 | 1: single-bit update, 0: value write |
| enq_bit | input | 6 | Bit position for a bit update |
| enq_value | input | 64 | Write value, or the set/clear selector for a bit update |
| full | output | 1 | All queue slots occupied |
| tick | input | 1 | Count down all pending entries this cycle |
| regs_o | output | NREG*64 | Target registers, register k at bits k*64+63:k*64 |
| err | output | 1 | Pointer mismatch on an empty queue |

## Verification
The properties assume that `tick` and `enq_valid` are sampled on the same edge. They also assume that register contents and occupancy can change only through those two inputs, so every check keys off their absence or off `full`. The stimulus therefore always drives a target index below `NREG` and a delay within `DLY_W` bits. It holds `rst_n` low for several edges before any traffic. The stimulus changes inputs only on the falling edge, so each rising edge sees one stable request.

// File: rtl/regupd_queue.sv
module regupd_queue #(
  parameter int SLOTS = 8,
  parameter int NREG  = 4,
  parameter int DLY_W = 4,
  parameter int TGT_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enq_valid,
  input  logic [TGT_W-1:0]     enq_tgt,
  input  logic [DLY_W-1:0]     enq_delay,
  input  logic                 enq_wide,
  input  logic                 enq_bit_en,
  input  logic [5:0]           enq_bit,
  input  logic [63:0]          enq_value,
  output logic                 full,
  input  logic                 tick,
  output logic [NREG*64-1:0]   regs_o,
  output logic                 err
);
  localparam int PW = $clog2(SLOTS);
  localparam int CW = $clog2(SLOTS + 1);
  localparam logic [CW:0] SLW = (CW+1)'(SLOTS);

  logic [TGT_W-1:0] s_tgt  [SLOTS];
  logic [DLY_W-1:0] s_dly  [SLOTS];
  logic [DLY_W-1:0] d_nxt  [SLOTS];
  logic             s_wide [SLOTS];
  logic [63:0]      s_val  [SLOTS];
  logic             s_ben  [SLOTS];
  logic [5:0]       s_bit  [SLOTS];
  logic             s_done [SLOTS];
  logic             dn_nxt [SLOTS];
  logic [63:0]      r_q    [NREG];
  logic [63:0]      r_nxt  [NREG];

  logic [PW-1:0] in_ptr, out_ptr, out_nxt, in_inc, ix;
  logic [CW-1:0] count, retire;
  logic [CW:0]   isum, osum;
  logic          accept, fire, pre;

  function automatic logic [63:0] upd(input logic [63:0] cur, input logic wide,
                                      input logic ben, input logic [5:0] bi,
                                      input logic [63:0] v);
    logic [63:0] m;
    m = wide ? (64'd1 << bi) : (64'd1 << bi[4:0]);
    if (ben) return (|v) ? (cur | m) : (cur & ~m);
    return wide ? v : {32'd0, v[31:0]};
  endfunction

  assign full   = (count == CW'(SLOTS));
  assign err    = (in_ptr != out_ptr) && (count == '0);
  assign accept = enq_valid && !full;
  assign in_inc = (in_ptr == PW'(SLOTS - 1)) ? '0 : in_ptr + PW'(1);

  always_comb begin
    r_nxt  = r_q;
    d_nxt  = s_dly;
    dn_nxt = s_done;
    retire = '0;
    pre    = 1'b1;
    isum   = '0;
    ix     = '0;
    fire   = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      isum = (CW+1)'(out_ptr) + (CW+1)'(k);
      if (isum >= SLW) isum = isum - SLW;
      ix   = isum[PW-1:0];
      fire = 1'b0;
      if (tick && (CW'(k) < count)) begin
        if (!s_done[ix]) begin
          d_nxt[ix] = s_dly[ix] - DLY_W'(1);
          fire      = (s_dly[ix] == DLY_W'(1));
        end
        if (fire) begin
          dn_nxt[ix]        = 1'b1;
          r_nxt[s_tgt[ix]]  = upd(r_nxt[s_tgt[ix]], s_wide[ix], s_ben[ix], s_bit[ix], s_val[ix]);
        end
        if (pre && (s_done[ix] || fire)) retire = retire + CW'(1);
        else                             pre    = 1'b0;
      end
    end
    osum = (CW+1)'(out_ptr) + (CW+1)'(retire);
    if (osum >= SLW) osum = osum - SLW;
    out_nxt = osum[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ptr  <= '0;
      out_ptr <= '0;
      count   <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        s_tgt[i]  <= '0;
        s_dly[i]  <= '0;
        s_wide[i] <= 1'b0;
        s_val[i]  <= '0;
        s_ben[i]  <= 1'b0;
        s_bit[i]  <= '0;
        s_done[i] <= 1'b0;
      end
      for (int j = 0; j < NREG; j++) r_q[j] <= '0;
    end else begin
      r_q     <= r_nxt;
      s_dly   <= d_nxt;
      s_done  <= dn_nxt;
      out_ptr <= out_nxt;
      count   <= count - retire + CW'(accept);
      if (accept) begin
        s_tgt[in_ptr]  <= enq_tgt;
        s_dly[in_ptr]  <= (enq_delay == '0) ? DLY_W'(1) : enq_delay;
        s_wide[in_ptr] <= enq_wide;
        s_val[in_ptr]  <= enq_value;
        s_ben[in_ptr]  <= enq_bit_en;
        s_bit[in_ptr]  <= enq_bit;
        s_done[in_ptr] <= 1'b0;
        in_ptr         <= in_inc;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_rd
    assign regs_o[g*64 +: 64] = r_q[g];
  end
endmodule

module regupd_queue_chk #(
  parameter int SLOTS = 8,
  parameter int NREG  = 4,
  parameter int CW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              enq_valid,
  input logic              full,
  input logic              err,
  input logic [CW-1:0]     count,
  input logic [NREG*64-1:0] regs
);
  // R10
  ptr_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n) !err);
  // R2
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(regs));
  // R9
  capacity_chk: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(SLOTS));
  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && enq_valid && !tick) |=> (full && $stable(count)));
  // R9
  accept_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && enq_valid && !tick) |=> (count == $past(count) + CW'(1)));
  // R8
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !enq_valid) |=> $stable(count));
endmodule

bind regupd_queue regupd_queue_chk #(.SLOTS(SLOTS), .NREG(NREG), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .enq_valid(enq_valid), .full(full),
  .err(err), .count(count), .regs(regs_o)
);

// File: tb/tb_regupd_queue.sv
module tb_regupd_queue;
  localparam int PERIOD = 10;
  localparam int SLOTS  = 8;
  localparam int NREG   = 4;
  localparam int DLY_W  = 4;
  localparam int TGT_W  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 1'b0, enq_wide = 1'b0, enq_bit_en = 1'b0, tick = 1'b0;
  logic [TGT_W-1:0] enq_tgt = '0;
  logic [DLY_W-1:0] enq_delay = '0;
  logic [5:0] enq_bit = '0;
  logic [63:0] enq_value = '0;
  logic full, err;
  logic [NREG*64-1:0] regs_o;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  typedef struct {
    int tgt; int dly; bit wide; logic [63:0] val; bit ben; int bi; bit done;
  } ent_t;
  ent_t q[$];
  logic [63:0] m_r [NREG];

  always #(PERIOD/2) clk = ~clk;

  regupd_queue #(.SLOTS(SLOTS), .NREG(NREG), .DLY_W(DLY_W), .TGT_W(TGT_W)) dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_tgt(enq_tgt),
    .enq_delay(enq_delay), .enq_wide(enq_wide), .enq_bit_en(enq_bit_en),
    .enq_bit(enq_bit), .enq_value(enq_value), .full(full), .tick(tick),
    .regs_o(regs_o), .err(err)
  );

  function automatic logic [63:0] m_apply(logic [63:0] cur, ent_t e);
    logic [63:0] r;
    int b;
    r = cur;
    if (e.ben) begin
      b = e.wide ? e.bi : (e.bi % 32);
      r[b] = (e.val != 64'd0);
    end else if (e.wide) r = e.val;
    else r = {32'h0, e.val[31:0]};
    return r;
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    for (int k = 0; k < NREG; k++) check(tag, $sformatf("reg%0d", k), regs_o[k*64 +: 64], m_r[k]);
    check(tag, "full", {63'd0, full}, {63'd0, q.size() == SLOTS});
    check(tag, "err", {63'd0, err}, 64'd0);
  endtask

  task automatic step(input bit en, input int tgt, input int dly, input bit wide,
                      input logic [63:0] val, input bit ben, input int bi,
                      input bit tk, input string tag);
    ent_t e;
    bit acc;
    enq_valid = en; enq_tgt = TGT_W'(tgt); enq_delay = DLY_W'(dly);
    enq_wide = wide; enq_value = val; enq_bit_en = ben; enq_bit = 6'(bi); tick = tk;
    @(posedge clk);
    acc = en && (q.size() < SLOTS);
    if (tk) begin
      foreach (q[i]) begin
        if (!q[i].done) begin
          q[i].dly--;
          if (q[i].dly == 0) begin
            m_r[q[i].tgt] = m_apply(m_r[q[i].tgt], q[i]);
            q[i].done = 1;
          end
        end
      end
      while (q.size() > 0 && q[0].done) void'(q.pop_front());
    end
    if (acc) begin
      e.tgt = tgt; e.dly = (dly == 0) ? 1 : dly; e.wide = wide; e.val = val;
      e.ben = ben; e.bi = bi; e.done = 0;
      q.push_back(e);
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic enq(input int tgt, input int dly, input bit wide, input logic [63:0] val,
                     input bit ben, input int bi, input string tag);
    step(1, tgt, dly, wide, val, ben, bi, 0, tag);
  endtask

  task automatic tk(input string tag);
    step(0, 0, 0, 0, 64'd0, 0, 0, 1, tag);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NREG; k++) m_r[k] = 64'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R1");
    check("R1", "reg0 after reset", regs_o[63:0], 64'd0);

    // R2 R3: wide write after three ticks
    enq(1, 3, 1, 64'hDEAD_BEEF_0123_4567, 0, 0, "R3");
    step(0, 0, 0, 0, 64'd0, 0, 0, 0, "R2");
    tk("R2"); tk("R2");
    check("R2", "reg1 before expiry", regs_o[127:64], 64'd0);
    tk("R3");
    check("R3", "reg1 wide write", regs_o[127:64], 64'hDEAD_BEEF_0123_4567);

    // R4 narrow write zero-fills the top half
    enq(2, 1, 1, '1, 0, 0, "R4"); tk("R4");
    enq(2, 1, 0, 64'hFFFF_FFFF_1234_5678, 0, 0, "R4"); tk("R4");
    check("R4", "reg2 narrow write", regs_o[191:128], 64'h0000_0000_1234_5678);

    // R6 narrow bit clear, position 37 folds to 5
    enq(2, 1, 1, '1, 0, 0, "R6"); tk("R6");
    enq(2, 1, 0, 64'd0, 1, 37, "R6"); tk("R6");
    check("R6", "reg2 narrow bit clear", regs_o[191:128], 64'hFFFF_FFFF_FFFF_FFDF);
    enq(2, 1, 0, 64'h1_0000_0000, 1, 5, "R6"); tk("R6");
    check("R6", "reg2 narrow bit set", regs_o[191:128], 64'hFFFF_FFFF_FFFF_FFFF);

    // R5 wide bit set and clear
    enq(0, 2, 1, 64'd5, 1, 63, "R5"); tk("R5"); tk("R5");
    check("R5", "reg0 bit63 set", regs_o[63:0], 64'h8000_0000_0000_0000);
    enq(0, 1, 1, 64'd0, 1, 63, "R5"); tk("R5");
    check("R5", "reg0 bit63 clear", regs_o[63:0], 64'd0);

    // R2 zero delay and enqueue during a tick
    enq(3, 0, 1, 64'h77, 0, 0, "R2"); tk("R2");
    check("R2", "reg3 zero delay", regs_o[255:192], 64'h77);
    step(1, 3, 1, 1, 64'h66, 0, 0, 1, "R2");
    check("R2", "reg3 not ticked at enqueue", regs_o[255:192], 64'h77);
    tk("R2");
    check("R2", "reg3 after next tick", regs_o[255:192], 64'h66);

    // R7 out-of-order application and same-tick ordering
    enq(3, 4, 1, 64'hAA, 0, 0, "R7"); enq(3, 2, 1, 64'hBB, 0, 0, "R7");
    tk("R7"); tk("R7");
    check("R7", "reg3 short delay first", regs_o[255:192], 64'hBB);
    tk("R7"); tk("R7");
    check("R7", "reg3 long delay later", regs_o[255:192], 64'hAA);
    enq(0, 2, 1, 64'h11, 0, 0, "R7"); enq(0, 2, 1, 64'h22, 0, 0, "R7");
    tk("R7"); tk("R7");
    check("R7", "reg0 same tick tail wins", regs_o[63:0], 64'h22);

    // R8 done entry is not applied twice
    enq(1, 5, 1, 64'h1, 0, 0, "R8"); enq(1, 1, 1, 64'h2, 0, 0, "R8");
    tk("R8");
    check("R8", "reg1 non-head applied", regs_o[127:64], 64'h2);
    enq(1, 2, 1, 64'h3, 0, 0, "R8");
    tk("R8"); tk("R8");
    check("R8", "reg1 third entry", regs_o[127:64], 64'h3);
    tk("R8"); tk("R8");
    check("R8", "reg1 head last, no reapply", regs_o[127:64], 64'h1);
    check("R8", "queue drained", {63'd0, full}, 64'd0);

    // R9 capacity, full flag, dropped enqueue
    enq(0, 9, 1, 64'h5A, 0, 0, "R9");
    for (int i = 0; i < 7; i++) enq(2, 1, 1, 64'h100 + 64'(i), 0, 0, "R9");
    check("R9", "full at capacity", {63'd0, full}, 64'd1);
    enq(2, 1, 1, 64'h99, 0, 0, "R9");
    tk("R9");
    check("R9", "still full, head pending", {63'd0, full}, 64'd1);
    check("R9", "reg2 last accepted", regs_o[191:128], 64'h106);
    for (int i = 0; i < 8; i++) tk("R9");
    check("R9", "reg0 head applied", regs_o[63:0], 64'h5A);
    check("R9", "reg2 dropped write absent", regs_o[191:128], 64'h106);
    check("R9", "empty after drain", {63'd0, full}, 64'd0);

    // R7 R8 R9 R10 mixed traffic
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 2) != 0, $urandom_range(0, NREG - 1), $urandom_range(0, 6),
           1'($urandom_range(0, 1)), {$urandom, $urandom}, $urandom_range(0, 3) == 0,
           $urandom_range(0, 63), $urandom_range(0, 2) == 0, "R7 R8 R9 R10");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule